// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds seven byte-wide configuration registers behind a pair of I/O addresses. Software first writes a register number to the index port (22h) and then makes exactly one read or write at the data port (24h). That one data access consumes the selection: the index drops back to an invalid state, so the next data access needs a fresh index write, even if it goes to the same register.

Register 10h is decoded into control fields for a neighbouring memory controller: a pipeline-mode enable, read and write wait-state selects, and a 4-bit DRAM bank configuration code. A revision parameter sets the read-only revision bit. It also decides whether pipeline mode and the extra bank code 1100 may be written. Registers 11h to 16h are plain storage bytes.

The bus side is a plain strobe interface with no back-pressure. The block takes every strobe in the cycle it appears and never stalls the bus. A data-port read is answered one clock later with a single-cycle `rd_valid` pulse, and `rd_data` holds its value between reads. Addresses other than the two ports are ignored.

Top module: `cfg_index_port`

## Requirements
- R1: A write strobe at address 22h stores the data byte as the index. A following write strobe at 24h loads the selected register. A following read strobe at 24h returns the selected register's contents on `rd_data` one clock later.
- R2: Any strobe at 24h makes the index invalid. A data write with no valid index changes no register, and a data read with no valid index returns FFh.
- R3: An index outside 10h..16h is accepted. The data access that follows changes no register, returns FFh on a read, and still makes the index invalid.
- R4: After reset, register 10h reads {REV,0,1,1,1111} (BFh when REV=1, 3Fh when REV=0), registers 11h..16h read 00h, `bank_cfg`=1111, `rd_ws`=1, `wr_ws`=1 and `pipe_en`=0.
- R5: Bit 7 of register 10h always reads the REV parameter value, and writes to it have no effect.
- R6: Bit 6 of register 10h drives `pipe_en` and is writable only when REV=1. When REV=0 it stays 0 and reads 0.
- R7: Bit 5 of register 10h drives `rd_ws` and bit 4 drives `wr_ws` (1 means one wait state).
- R8: Bits 3:0 of register 10h drive `bank_cfg`. When REV=0, a write carrying code 1100 leaves the bank field unchanged but still updates bits 6:4. Any other code, and any code when REV=1, is stored.
- R9: Registers 11h..16h are independent 8-bit read/write bytes.
- R10: `rd_valid` is high for exactly the one clock after a read strobe at 24h that has no write strobe with it. A write strobe together with a read strobe is treated as a write. Strobes at other addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address of the current strobe |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe, one per access cycle |
| io_rd | input | 1 | Read strobe, one per access cycle |
| rd_data | output | 8 | Read data, held between reads |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` as the answer to a data read |
| pipe_en | output | 1 | Pipeline mode enable (register 10h bit 6) |
| rd_ws | output | 1 | Read wait-state select (bit 5) |
| wr_ws | output | 1 | Write wait-state select (bit 4) |
| bank_cfg | output | 4 | DRAM bank configuration code (bits 3:0) |

## Verification
The bench builds two copies side by side from the same stimulus. One uses REV=1 and the other REV=0, and both keep the default addresses, base index and register count. Running both revisions brings the revision-dependent cases within reach in the same cycles: the pipeline bit that sticks only on the later revision, and code 1100 being taken by one copy and refused by the other. Out-of-range indices on both sides of 10h..16h, repeated data accesses without a new index, and a write strobe together with a read strobe exercise the cancellation and ignore rules against the reference model.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef struct packed {
    logic       pipe;
    logic       rws;
    logic       wws;
    logic [3:0] bank;
  } main_cfg_t;

  localparam logic [3:0] BANK_LATE_CODE = 4'hC;
  localparam main_cfg_t  MAIN_RST = '{pipe: 1'b0, rws: 1'b1, wws: 1'b1, bank: 4'hF};
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
  parameter int ADDR_W    = 10,
  parameter int IDX_PORT  = 'h22,
  parameter int DATA_PORT = 'h24,
  parameter int BASE      = 'h10,
  parameter int NREG      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              idx_vld,
  output logic [NREG-1:0]   sel,
  output logic              dwr,
  output logic              drd
);
  localparam logic [ADDR_W-1:0] IDX_A  = ADDR_W'(IDX_PORT);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_PORT);

  logic [7:0] idx_q;
  logic       iwr;
  logic       dacc;

  assign iwr  = io_wr && (io_addr == IDX_A);
  assign dacc = (io_wr || io_rd) && (io_addr == DATA_A);
  assign dwr  = io_wr && (io_addr == DATA_A);
  assign drd  = io_rd && !io_wr && (io_addr == DATA_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= 8'h00;
      idx_vld <= 1'b0;
    end else if (iwr) begin
      idx_q   <= io_wdata;
      idx_vld <= 1'b1;
    end else if (dacc) begin
      idx_vld <= 1'b0;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign sel[g] = idx_vld && (idx_q == 8'(BASE + g));
  end
endmodule

// File: rtl/cfg_main_reg.sv
module cfg_main_reg
  import cfg_pkg::*;
#(
  parameter bit REV = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output main_cfg_t  q,
  output logic [7:0] rdata
);
  logic bank_ok;

  assign bank_ok = REV || (wdata[3:0] != BANK_LATE_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= MAIN_RST;
    end else if (we) begin
      q.pipe <= REV ? wdata[6] : 1'b0;
      q.rws  <= wdata[5];
      q.wws  <= wdata[4];
      if (bank_ok) q.bank <= wdata[3:0];
    end
  end

  assign rdata = {REV, q.pipe, q.rws, q.wws, q.bank};
endmodule

// File: rtl/cfg_plain_regs.sv
module cfg_plain_regs #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] we,
  input  logic [7:0]   wdata,
  output logic [N*8-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)     q[g*8 +: 8] <= 8'h00;
      else if (we[g]) q[g*8 +: 8] <= wdata;
    end
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int IDX_PORT  = 'h22,
  parameter int DATA_PORT = 'h24,
  parameter int BASE      = 'h10,
  parameter int NREG      = 7,
  parameter bit REV       = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              pipe_en,
  output logic              rd_ws,
  output logic              wr_ws,
  output logic [3:0]        bank_cfg
);
  localparam int NPLAIN = NREG - 1;

  logic              idx_vld;
  logic [NREG-1:0]   sel;
  logic              dwr;
  logic              drd;
  main_cfg_t         main_q;
  logic [7:0]        main_rd;
  logic [NPLAIN*8-1:0] plain_q;
  logic [7:0]        rmux;

  cfg_port_decode #(
    .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT),
    .BASE(BASE), .NREG(NREG)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .idx_vld(idx_vld), .sel(sel),
    .dwr(dwr), .drd(drd)
  );

  cfg_main_reg #(.REV(REV)) u_main (
    .clk(clk), .rst_n(rst_n), .we(dwr && sel[0]), .wdata(io_wdata),
    .q(main_q), .rdata(main_rd)
  );

  cfg_plain_regs #(.N(NPLAIN)) u_plain (
    .clk(clk), .rst_n(rst_n), .we(sel[NREG-1:1] & {NPLAIN{dwr}}),
    .wdata(io_wdata), .q(plain_q)
  );

  always_comb begin
    rmux = 8'hFF;
    if (sel[0]) rmux = main_rd;
    for (int i = 1; i < NREG; i++) begin
      if (sel[i]) rmux = plain_q[(i-1)*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= 8'hFF;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= drd;
      if (drd) rd_data <= rmux;
    end
  end

  assign pipe_en  = main_q.pipe;
  assign rd_ws    = main_q.rws;
  assign wr_ws    = main_q.wws;
  assign bank_cfg = main_q.bank;
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
  parameter int ADDR_W    = 10,
  parameter int DATA_PORT = 'h24,
  parameter bit REV       = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        rd_data,
  input logic              rd_valid,
  input logic              pipe_en,
  input logic              rd_ws,
  input logic              wr_ws,
  input logic [3:0]        bank_cfg,
  input logic              idx_vld
);
  logic at_data;
  assign at_data = (io_addr == ADDR_W'(DATA_PORT));

  // R2
  index_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_wr || io_rd) && at_data) |=> !idx_vld);

  // R10
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && at_data) |=> rd_valid);

  // R10
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && !io_wr && at_data) |=> !rd_valid);

  // R2
  stale_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && at_data && !idx_vld) |=> (rd_data == 8'hFF));

  // R2
  stale_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && at_data && !idx_vld) |=>
      ($stable(bank_cfg) && $stable(rd_ws) && $stable(wr_ws) && $stable(pipe_en)));

  // R6
  pipe_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (REV == 1'b0) |-> !pipe_en);

  // R8
  late_code_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (REV == 1'b0) |-> (bank_cfg != 4'hC));
endmodule

bind cfg_index_port cfg_index_port_chk #(
  .ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .REV(REV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .rd_data(rd_data), .rd_valid(rd_valid), .pipe_en(pipe_en), .rd_ws(rd_ws),
  .wr_ws(wr_ws), .bank_cfg(bank_cfg), .idx_vld(idx_vld)
);

// File: tb/sim_cfg_index_port.sv
module sim_cfg_index_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;

  logic [7:0] rd_data [2];
  logic       rd_valid [2];
  logic       pipe_en [2];
  logic       rd_ws [2];
  logic       wr_ws [2];
  logic [3:0] bank_cfg [2];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model: index 0 is REV=1 (u0), index 1 is REV=0 (u1)
  logic [7:0] m_reg [2][7];
  logic [7:0] m_rd [2];
  bit         m_rv;
  int         m_idx;

  always #5 clk = ~clk;

  cfg_index_port #(.REV(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .rd_data(rd_data[0]), .rd_valid(rd_valid[0]),
    .pipe_en(pipe_en[0]), .rd_ws(rd_ws[0]), .wr_ws(wr_ws[0]), .bank_cfg(bank_cfg[0])
  );

  cfg_index_port #(.REV(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .rd_data(rd_data[1]), .rd_valid(rd_valid[1]),
    .pipe_en(pipe_en[1]), .rd_ws(rd_ws[1]), .wr_ws(wr_ws[1]), .bank_cfg(bank_cfg[1])
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < 2; r++) begin
      m_reg[r][0] = (r == 0) ? 8'hBF : 8'h3F;
      for (int k = 1; k < 7; k++) m_reg[r][k] = 8'h00;
      m_rd[r] = 8'hFF;
    end
    m_rv  = 1'b0;
    m_idx = -1;
  endtask

  function automatic logic [7:0] main_next(int r, logic [7:0] old, logic [7:0] v);
    bit late = (r == 0);
    logic [3:0] b = (!late && v[3:0] == 4'hC) ? old[3:0] : v[3:0];
    return {late, late ? v[6] : 1'b0, v[5:4], b};
  endfunction

  task automatic model_step();
    m_rv = 1'b0;
    if (io_wr && io_addr == 10'h22) begin
      m_idx = io_wdata;
    end else if ((io_wr || io_rd) && io_addr == 10'h24) begin
      for (int r = 0; r < 2; r++) begin
        if (m_idx >= 'h10 && m_idx <= 'h16) begin
          if (io_wr) begin
            if (m_idx == 'h10) m_reg[r][0] = main_next(r, m_reg[r][0], io_wdata);
            else m_reg[r][m_idx-'h10] = io_wdata;
          end else begin
            m_rd[r] = m_reg[r][m_idx-'h10];
          end
        end else if (!io_wr) begin
          m_rd[r] = 8'hFF;
        end
      end
      m_rv  = io_rd && !io_wr;
      m_idx = -1;
    end
  endtask

  task automatic compare_all();
    for (int r = 0; r < 2; r++) begin
      chk("R10 rd_valid", rd_valid[r], m_rv);
      if (m_rv) chk("R1 rd_data", rd_data[r], m_rd[r]);
      chk("R6 pipe_en", pipe_en[r], m_reg[r][0][6]);
      chk("R7 rd_ws", rd_ws[r], m_reg[r][0][5]);
      chk("R7 wr_ws", wr_ws[r], m_reg[r][0][4]);
      chk("R8 bank_cfg", bank_cfg[r], m_reg[r][0][3:0]);
    end
  endtask

  task automatic cyc(bit wr, bit rd, logic [9:0] a, logic [7:0] d);
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
    @(posedge clk);
    #1;
    if (rst_n) model_step();
    compare_all();
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  task automatic idx_wr(logic [7:0] i); cyc(1'b1, 1'b0, 10'h22, i); endtask
  task automatic dat_wr(logic [7:0] d); cyc(1'b1, 1'b0, 10'h24, d); endtask
  task automatic dat_rd();              cyc(1'b0, 1'b1, 10'h24, 8'h00); endtask

  task automatic rd_expect(string tag, logic [7:0] i, logic [7:0] e0, logic [7:0] e1);
    idx_wr(i);
    dat_rd();
    chk(tag, rd_data[0], e0);
    chk(tag, rd_data[1], e1);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R4 reset state
    compare_all();
    chk("R4 bank reset", bank_cfg[0], 4'hF);
    chk("R4 ws reset", {rd_ws[1], wr_ws[1], pipe_en[1]}, 3'b110);
    rd_expect("R4 R5 reg10 reset", 8'h10, 8'hBF, 8'h3F);
    rd_expect("R4 reg13 reset", 8'h13, 8'h00, 8'h00);

    // R6 R7 R5: bit7 write attempt, pipeline set only on REV=1
    idx_wr(8'h10); dat_wr(8'h4A);
    rd_expect("R6 R7 reg10 write", 8'h10, 8'hCA, 8'h0A);

    // R2: stale accesses after cancellation
    dat_rd();
    chk("R2 stale read", rd_data[0], 8'hFF);
    dat_wr(8'h00);
    rd_expect("R2 stale write ignored", 8'h10, 8'hCA, 8'h0A);
    idx_wr(8'h10); dat_wr(8'hF5); dat_wr(8'h00);
    rd_expect("R2 second write ignored", 8'h10, 8'hF5, 8'h35);

    // R8: code 1100 gated by revision
    idx_wr(8'h10); dat_wr(8'h3C);
    rd_expect("R8 late code", 8'h10, 8'hBC, 8'h35);
    idx_wr(8'h10); dat_wr(8'h07);
    rd_expect("R8 plain code", 8'h10, 8'h87, 8'h07);

    // R9: plain bytes
    for (int k = 1; k < 7; k++) begin
      idx_wr(8'(8'h10 + k)); dat_wr(8'(8'h11 * k + 8'h20));
    end
    for (int k = 1; k < 7; k++)
      rd_expect("R9 plain byte", 8'(8'h10 + k), 8'(8'h11 * k + 8'h20), 8'(8'h11 * k + 8'h20));

    // R3: out-of-range indices
    idx_wr(8'h17); dat_wr(8'h00);
    idx_wr(8'h0F); dat_wr(8'h00);
    idx_wr(8'h17); dat_rd();
    chk("R3 out of range read", rd_data[1], 8'hFF);
    dat_wr(8'hAA);
    rd_expect("R3 reg10 unchanged", 8'h10, 8'h87, 8'h07);

    // R10: other addresses, rd with wr, and back-to-back traffic
    cyc(1'b1, 1'b0, 10'h23, 8'h55);
    cyc(1'b0, 1'b1, 10'h22, 8'h00);
    chk("R10 other address no pulse", rd_valid[0], 1'b0);
    idx_wr(8'h11); cyc(1'b1, 1'b1, 10'h24, 8'h66);
    chk("R10 rd with wr no pulse", rd_valid[0], 1'b0);
    rd_expect("R10 rd with wr wrote", 8'h11, 8'h66, 8'h66);
    cyc(1'b1, 1'b0, 10'h124, 8'h00);
    dat_rd();
    chk("R1 alias address ignored", rd_data[0], 8'hFF);
    idx_wr(8'h10); dat_wr(8'hFC);
    rd_expect("R1 R8 final", 8'h10, 8'hFC, 8'h37);
    repeat (3) cyc(1'b0, 1'b0, 10'h00, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule